// File: doc/BRIEF.md
# Quad DAC Serial Write Controller

This block sits on the host side of a four-channel, 12-bit, voltage-output DAC that is written over a three-wire serial link: a shift clock, a data line and an active-low chip select. It also drives an active-low load strobe and an active-low asynchronous reset. A reset-select level goes with the reset.

A write request carries a 2-bit channel number and a 12-bit code over a valid/ready handshake. The block then builds a 16-bit frame, shifts it out most significant bit first, and releases chip select. It pulses the load strobe so that the addressed channel takes the new code. A separate reset request drives the reset-select level and then pulses the reset line. Every interface interval is a parameter in nanoseconds. The block turns each one into a count of system-clock cycles by dividing by the clock period and rounding up. An optional wait after each load keeps the block busy until the analog output has had time to settle.

Top module: `quad_dac_link`

## Requirements
- R1: After synchronous reset, and whenever the block is idle, the outputs are `dac_sclk`=0, `dac_sdi`=0, `dac_cs_n`=1, `dac_load_n`=1 and `dac_rst_n`=1. In that state `req_ready`=1 unless `init_valid` is high.
- R2: A write is taken on a clock edge where `req_valid` and `req_ready` are both 1, and `req_chan`/`req_code` are captured on that edge. `req_ready` then stays 0 until the whole sequence ends. A `req_valid` raised while busy starts no second frame and does not change the frame in progress.
- R3: Each write produces exactly 16 rising edges of `dac_sclk` while `dac_cs_n`=0. The bits sampled on those edges are, in order: `req_chan[1]`, `req_chan[0]`, two filler bits driven as 0, then `req_code[11]` down to `req_code[0]`.
- R4: Every high phase of `dac_sclk` lasts at least ceil(max(T_CH_NS, T_DH_NS)/CLK_NS) cycles. Every low phase between two rising edges lasts at least ceil(max(T_CL_NS, T_DS_NS)/CLK_NS) cycles.
- R5: `dac_sdi` never changes while `dac_sclk` is 1. It holds its value for at least ceil(T_DS_NS/CLK_NS) cycles before each rising edge.
- R6: `dac_sclk` is 0 whenever `dac_cs_n` is 1. `dac_cs_n` falls at least ceil(T_CSS_NS/CLK_NS) cycles before the first rising edge and falls once per write. It stays 0 for at least ceil(T_CSH_NS/CLK_NS) cycles after the last falling edge of `dac_sclk`.
- R7: Each write gives exactly one low pulse on `dac_load_n`, and only while `dac_cs_n`=1. The pulse lasts at least ceil(T_LDW_NS/CLK_NS) cycles and starts at least ceil(T_LD2_NS/CLK_NS) cycles after the last rising edge of `dac_sclk`.
- R8: After `dac_load_n` rises, `req_ready` stays 0 for at least ceil(T_LD1_NS/CLK_NS) cycles. When SETTLE_WAIT=1 it stays 0 for at least ceil(T_SETTLE_NS/CLK_NS) cycles instead.
- R9: A reset request (`init_valid`=1 while idle) copies `init_sel` to `dac_rstsel`. That value holds for at least ceil(T_RSS_NS/CLK_NS) cycles before `dac_rst_n` falls and stays stable while `dac_rst_n`=0. `dac_rst_n` stays 0 for at least ceil(T_RSW_NS/CLK_NS) cycles. `dac_cs_n` and `dac_load_n` stay 1 throughout.
- R10: While `init_valid`=1, `req_ready`=0. When both requests are present at idle, the reset sequence runs in full before the held write starts its frame.
- R11: A synchronous reset in the middle of a frame returns every DAC-side output to the R1 values on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can take a write |
| req_chan | input | 2 | Target channel number |
| req_code | input | 12 | Code for the target channel |
| init_valid | input | 1 | Reset-sequence request, taken when idle, takes priority over a write |
| init_sel | input | 1 | Reset-select level captured with the reset request |
| dac_sclk | output | 1 | Serial shift clock, rests low |
| dac_sdi | output | 1 | Serial data, rests low |
| dac_cs_n | output | 1 | Active-low chip select |
| dac_load_n | output | 1 | Active-low load strobe |
| dac_rst_n | output | 1 | Active-low DAC reset pulse |
| dac_rstsel | output | 1 | Reset-select level |

## Verification
The bench uses the default parameters: a 4 ns clock, the DAC's own nanosecond minimums, and the settle wait turned on at 10 us. This gives cycle minimums of 8 (clock high), 13 (clock low), 14 (select lead), 12 (load pulse), 18 (reset pulse) and 2500 (settle). The settle window is short enough that each write, including the full busy period, runs in a few thousand cycles. So every guard interval, both reset-select levels and the priority case can be measured edge by edge against bounds that the bench derives from the nanosecond figures.

// File: rtl/qdl_pkg.sv
package qdl_pkg;

  localparam int ADDR_W  = 2;
  localparam int PAD_W   = 2;
  localparam int CODE_W  = 12;
  localparam int FRAME_W = ADDR_W + PAD_W + CODE_W;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HI,
    ST_LO,
    ST_TAIL,
    ST_LOAD,
    ST_GUARD,
    ST_RSEL,
    ST_RST
  } qdl_state_e;

  // whole cycles covering a time in ns, never below one
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/qdl_phase_timer.sv
module qdl_phase_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/qdl_frame_shift.sv
module qdl_frame_shift
  import qdl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PAD_W,
  parameter int DW = CODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] code,
  input  logic          shift,
  input  logic          clear,
  output logic          bit_o,
  output logic          last
);

  localparam int FW = AW + PW + DW;
  localparam int LW = $clog2(FW);

  logic [FW-1:0] sreg;
  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      left <= '0;
    end else if (load) begin
      sreg <= {addr, {PW{1'b0}}, code};
      left <= LW'(FW - 1);
    end else if (clear) begin
      sreg <= '0;
      left <= '0;
    end else if (shift) begin
      sreg <= {sreg[FW-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end

  assign bit_o = sreg[FW-1];
  assign last  = (left == '0);

  assert_shift_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
    shift |-> (left != '0));

  assert_load_when_drained_R2: assert property (@(posedge clk) disable iff (rst)
    load |-> (left == '0));

endmodule

// File: rtl/quad_dac_link.sv
module quad_dac_link
  import qdl_pkg::*;
#(
  parameter int CLK_NS      = 4,
  parameter int T_DS_NS     = 25,
  parameter int T_DH_NS     = 20,
  parameter int T_CH_NS     = 30,
  parameter int T_CL_NS     = 50,
  parameter int T_CSS_NS    = 55,
  parameter int T_CSH_NS    = 15,
  parameter int T_LD1_NS    = 40,
  parameter int T_LD2_NS    = 15,
  parameter int T_LDW_NS    = 45,
  parameter int T_RSS_NS    = 25,
  parameter int T_RSW_NS    = 70,
  parameter int T_SETTLE_NS = 10000,
  parameter bit SETTLE_WAIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_chan,
  input  logic [CODE_W-1:0] req_code,
  input  logic              init_valid,
  input  logic              init_sel,
  output logic              dac_sclk,
  output logic              dac_sdi,
  output logic              dac_cs_n,
  output logic              dac_load_n,
  output logic              dac_rst_n,
  output logic              dac_rstsel
);

  localparam int C_HI    = imax(ns_to_cyc(T_CH_NS, CLK_NS), ns_to_cyc(T_DH_NS, CLK_NS));
  localparam int C_LO    = imax(ns_to_cyc(T_CL_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS));
  localparam int C_LEAD  = imax(ns_to_cyc(T_CSS_NS, CLK_NS), C_LO);
  localparam int C_TAIL  = imax(ns_to_cyc(T_CSH_NS, CLK_NS), ns_to_cyc(T_LD2_NS, CLK_NS));
  localparam int C_LDW   = ns_to_cyc(T_LDW_NS, CLK_NS);
  localparam int C_LD1   = ns_to_cyc(T_LD1_NS, CLK_NS);
  localparam int C_GUARD = SETTLE_WAIT ? imax(C_LD1, ns_to_cyc(T_SETTLE_NS, CLK_NS)) : C_LD1;
  localparam int C_RSEL  = ns_to_cyc(T_RSS_NS, CLK_NS);
  localparam int C_RSTW  = ns_to_cyc(T_RSW_NS, CLK_NS);
  localparam int C_MAX   = imax(imax(imax(C_HI, C_LO), imax(C_LEAD, C_TAIL)),
                                imax(imax(C_LDW, C_GUARD), imax(C_RSEL, C_RSTW)));
  localparam int TW      = $clog2(C_MAX + 1);

  qdl_state_e    state, state_nx;
  logic          idle_q;
  logic          wr_take, init_take;
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic          sh_last, sh_shift, sh_clear, sh_bit;

  // a pending reset request masks the write handshake
  assign req_ready = idle_q & ~init_valid;
  assign init_take = idle_q & init_valid;
  assign wr_take   = req_valid & req_ready;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (init_take) state_nx = ST_RSEL;
                else if (wr_take) state_nx = ST_LEAD;
      ST_LEAD:  if (tmr_done) state_nx = ST_HI;
      ST_HI:    if (tmr_done) state_nx = sh_last ? ST_TAIL : ST_LO;
      ST_LO:    if (tmr_done) state_nx = ST_HI;
      ST_TAIL:  if (tmr_done) state_nx = ST_LOAD;
      ST_LOAD:  if (tmr_done) state_nx = ST_GUARD;
      ST_GUARD: if (tmr_done) state_nx = ST_IDLE;
      ST_RSEL:  if (tmr_done) state_nx = ST_RST;
      ST_RST:   if (tmr_done) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_nx)
      ST_LEAD:  tmr_val = TW'(C_LEAD - 1);
      ST_HI:    tmr_val = TW'(C_HI - 1);
      ST_LO:    tmr_val = TW'(C_LO - 1);
      ST_TAIL:  tmr_val = TW'(C_TAIL - 1);
      ST_LOAD:  tmr_val = TW'(C_LDW - 1);
      ST_GUARD: tmr_val = TW'(C_GUARD - 1);
      ST_RSEL:  tmr_val = TW'(C_RSEL - 1);
      ST_RST:   tmr_val = TW'(C_RSTW - 1);
      default:  tmr_val = '0;
    endcase
  end

  assign tmr_load = (state_nx != state);
  assign sh_shift = (state == ST_HI) && (state_nx == ST_LO);
  assign sh_clear = (state == ST_HI) && (state_nx == ST_TAIL);

  qdl_phase_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  qdl_frame_shift #(.AW(ADDR_W), .PW(PAD_W), .DW(CODE_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load  (wr_take),
    .addr  (req_chan),
    .code  (req_code),
    .shift (sh_shift),
    .clear (sh_clear),
    .bit_o (sh_bit),
    .last  (sh_last)
  );

  // every pin is a register set from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idle_q     <= 1'b1;
      dac_sclk   <= 1'b0;
      dac_cs_n   <= 1'b1;
      dac_load_n <= 1'b1;
      dac_rst_n  <= 1'b1;
      dac_rstsel <= 1'b0;
    end else begin
      state      <= state_nx;
      idle_q     <= (state_nx == ST_IDLE);
      dac_sclk   <= (state_nx == ST_HI);
      dac_cs_n   <= !(state_nx inside {ST_LEAD, ST_HI, ST_LO, ST_TAIL});
      dac_load_n <= (state_nx != ST_LOAD);
      dac_rst_n  <= (state_nx != ST_RST);
      if (init_take) dac_rstsel <= init_sel;
    end
  end

  assign dac_sdi = sh_bit;

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (dac_cs_n && dac_load_n && dac_rst_n && !dac_sclk && !dac_sdi));

  assert_sdi_still_high_R5: assert property (@(posedge clk) disable iff (rst)
    dac_sclk |-> $stable(dac_sdi));

  assert_sclk_gated_R6: assert property (@(posedge clk) disable iff (rst)
    dac_cs_n |-> !dac_sclk);

  assert_load_outside_frame_R7: assert property (@(posedge clk) disable iff (rst)
    !dac_load_n |-> dac_cs_n);

  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !dac_rst_n |-> (dac_cs_n && dac_load_n && !req_ready));

  assert_rstsel_steady_R9: assert property (@(posedge clk) disable iff (rst)
    !dac_rst_n |-> $stable(dac_rstsel));

  assert_init_first_R10: assert property (@(posedge clk) disable iff (rst)
    init_valid |-> !req_ready);

endmodule

// File: tb/quad_dac_link_bench.sv
module quad_dac_link_bench;

  function automatic int cyc(input int t_ns);
    return (t_ns + 3) / 4;
  endfunction

  localparam int M_HI   = (cyc(30) > cyc(20)) ? cyc(30) : cyc(20);
  localparam int M_LO   = (cyc(50) > cyc(25)) ? cyc(50) : cyc(25);
  localparam int M_DS   = cyc(25);
  localparam int M_CSS  = cyc(55);
  localparam int M_CSH  = cyc(15);
  localparam int M_LD2  = cyc(15);
  localparam int M_LDW  = cyc(45);
  localparam int M_SETL = cyc(10000);
  localparam int M_RSS  = cyc(25);
  localparam int M_RSW  = cyc(70);

  // {chan, code, expected frame}
  localparam logic [29:0] VEC [0:5] = '{
    {2'd0, 12'h000, 16'h0000},
    {2'd1, 12'hFFF, 16'h4FFF},
    {2'd2, 12'hA5A, 16'h8A5A},
    {2'd3, 12'h5A5, 16'hC5A5},
    {2'd0, 12'h800, 16'h0800},
    {2'd3, 12'h001, 16'hC001}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_chan = '0;
  logic [11:0] req_code = '0;
  logic        init_valid = 1'b0;
  logic        init_sel = 1'b0;
  logic        dac_sclk, dac_sdi, dac_cs_n, dac_load_n, dac_rst_n, dac_rstsel;

  always #2 clk = ~clk;

  quad_dac_link u_quad_dac_link (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_code(req_code), .init_valid(init_valid),
    .init_sel(init_sel), .dac_sclk(dac_sclk), .dac_sdi(dac_sdi),
    .dac_cs_n(dac_cs_n), .dac_load_n(dac_load_n), .dac_rst_n(dac_rst_n),
    .dac_rstsel(dac_rstsel)
  );

  int n_chk = 0, n_bad = 0, cycle = 0;
  bit finished = 0;

  // monitor state, cleared on request from stimulus
  int clr_req = 0, clr_seen = 0;
  int rises, cs_falls, load_falls, rst_falls, run, min_hi, min_lo, sdi_age, min_age;
  int hi_change, lead, cs_low, since_fall, tail, since_rise, gap, ld_cnt, ld_w;
  int settle, since_ld, rsel_age, rsel_age_at, rsel_at, rst_cnt, rst_w;
  int first_rst_cyc, first_cs_cyc;
  bit settle_trk;
  logic [15:0] frame;
  logic p_sclk = 0, p_sdi = 0, p_cs = 1, p_load = 1, p_rst = 1, p_rsel = 0;

  always @(negedge clk) begin
    cycle++;
    if (clr_seen != clr_req) begin
      clr_seen = clr_req;
      rises = 0; cs_falls = 0; load_falls = 0; rst_falls = 0; run = 1;
      min_hi = 1000000; min_lo = 1000000; min_age = 1000000; hi_change = 0;
      lead = -1; cs_low = 0; since_fall = 0; tail = -1; since_rise = 0; gap = -1;
      ld_cnt = 0; ld_w = -1; settle = -1; since_ld = 0; settle_trk = 0;
      rsel_age = 1; rsel_age_at = -1; rsel_at = -1; rst_cnt = 0; rst_w = -1;
      first_rst_cyc = -1; first_cs_cyc = -1; frame = '0;
    end
    if (!rst) begin
      if (dac_sdi != p_sdi) begin
        sdi_age = 1;
        if (dac_sclk && p_sclk) hi_change++;
      end else sdi_age++;
      if (dac_sclk != p_sclk) begin
        if (p_sclk && run < min_hi) min_hi = run;
        if (!p_sclk && rises > 0 && run < min_lo) min_lo = run;
        run = 1;
      end else run++;
      if (!dac_cs_n) cs_low++;
      if (!dac_cs_n && p_cs) begin
        cs_falls++; cs_low = 1;
        if (first_cs_cyc < 0) first_cs_cyc = cycle;
      end
      since_rise++;
      if (dac_sclk && !p_sclk) begin
        if (rises == 0) lead = cs_low - 1;
        if (sdi_age - 1 < min_age) min_age = sdi_age - 1;
        frame = {frame[14:0], dac_sdi};
        rises++; since_rise = 0;
      end
      if (!dac_sclk && p_sclk) since_fall = 1; else if (!dac_sclk) since_fall++;
      if (dac_cs_n && !p_cs) tail = since_fall - 1;
      if (settle_trk) begin
        since_ld++;
        if (req_ready) begin settle = since_ld; settle_trk = 0; end
      end
      if (!dac_load_n && p_load) begin load_falls++; gap = since_rise; ld_cnt = 0; end
      if (!dac_load_n) ld_cnt++;
      if (dac_load_n && !p_load) begin ld_w = ld_cnt; since_ld = 0; settle_trk = 1; end
      if (dac_rstsel != p_rsel) rsel_age = 1; else rsel_age++;
      if (!dac_rst_n && p_rst) begin
        rst_falls++; rsel_at = dac_rstsel; rsel_age_at = rsel_age - 1; rst_cnt = 0;
        if (first_rst_cyc < 0) first_rst_cyc = cycle;
      end
      if (!dac_rst_n) rst_cnt++;
      if (dac_rst_n && !p_rst) rst_w = rst_cnt;
    end
    p_sclk = dac_sclk; p_sdi = dac_sdi; p_cs = dac_cs_n;
    p_load = dac_load_n; p_rst = dac_rst_n; p_rsel = dac_rstsel;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    clr_req++;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && !req_ready; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [1:0] ch, input logic [11:0] cd);
    while (!req_ready) @(negedge clk);
    req_chan = ch; req_code = cd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_init(input logic sel);
    while (!req_ready) @(negedge clk);
    init_sel = sel; init_valid = 1'b1;
    @(negedge clk);
    init_valid = 1'b0;
  endtask

  task automatic check_write(input logic [15:0] exp);
    check(frame == exp, "R3", "frame bits", int'(frame), int'(exp));
    check(rises == 16, "R3", "rising edges", rises, 16);
    check(min_hi >= M_HI, "R4", "min sclk high", min_hi, M_HI);
    check(min_lo >= M_LO, "R4", "min sclk low", min_lo, M_LO);
    check(hi_change == 0, "R5", "sdi moved while high", hi_change, 0);
    check(min_age >= M_DS, "R5", "sdi setup", min_age, M_DS);
    check(lead >= M_CSS, "R6", "select lead", lead, M_CSS);
    check(tail >= M_CSH, "R6", "select hold", tail, M_CSH);
    check(cs_falls == 1, "R6", "select falls", cs_falls, 1);
    check(load_falls == 1, "R7", "load pulses", load_falls, 1);
    check(ld_w >= M_LDW, "R7", "load width", ld_w, M_LDW);
    check(gap >= M_LD2, "R7", "rise to load", gap, M_LD2);
    check(settle >= M_SETL, "R8", "busy after load", settle, M_SETL);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    clear_mon();
    // R1: rest state after reset
    check(!dac_sclk && !dac_sdi, "R1", "sclk/sdi idle", {dac_sclk, dac_sdi}, 0);
    check(dac_cs_n && dac_load_n && dac_rst_n, "R1", "cs/load/rst idle",
          {dac_cs_n, dac_load_n, dac_rst_n}, 7);
    check(req_ready, "R1", "ready after reset", req_ready, 1);

    // table-driven writes: R3..R8
    foreach (VEC[i]) begin
      clear_mon();
      send(VEC[i][29:28], VEC[i][27:16]);
      check(!req_ready, "R2", "ready drops after take", req_ready, 0);
      wait_idle();
      check_write(VEC[i][15:0]);
    end

    // R2: valid while busy is ignored
    begin
      int seen_ready = 0;
      clear_mon();
      send(2'd2, 12'h3C7);
      repeat (40) @(negedge clk);
      req_chan = 2'd1; req_code = 12'hFFF; req_valid = 1'b1;
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        if (req_ready) seen_ready++;
      end
      req_valid = 1'b0;
      check(seen_ready == 0, "R2", "ready while busy", seen_ready, 0);
      wait_idle();
      check(frame == 16'h83C7, "R2", "frame kept", int'(frame), 16'h83C7);
      check(cs_falls == 1 && rises == 16, "R2", "no extra frame", cs_falls, 1);
    end

    // R9: reset sequence with both select levels
    for (int s = 1; s >= 0; s--) begin
      clear_mon();
      send_init(s[0]);
      wait_idle();
      check(rst_falls == 1, "R9", "reset pulses", rst_falls, 1);
      check(rsel_at == s, "R9", "select level", rsel_at, s);
      check(rsel_age_at >= M_RSS, "R9", "select lead", rsel_age_at, M_RSS);
      check(rst_w >= M_RSW, "R9", "reset width", rst_w, M_RSW);
      check(cs_falls == 0 && load_falls == 0, "R9", "link quiet", cs_falls + load_falls, 0);
    end

    // R10: reset request beats a simultaneous write
    clear_mon();
    while (!req_ready) @(negedge clk);
    init_sel = 1'b1; init_valid = 1'b1;
    req_chan = 2'd1; req_code = 12'h456; req_valid = 1'b1;
    #1;
    check(!req_ready, "R10", "ready masked", req_ready, 0);
    @(negedge clk);
    init_valid = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (req_ready) begin
        @(negedge clk);
        req_valid = 1'b0;
        break;
      end
    end
    req_valid = 1'b0;
    wait_idle();
    check(rst_falls == 1 && cs_falls == 1, "R10", "both ran", rst_falls + cs_falls, 2);
    check(first_rst_cyc >= 0 && first_rst_cyc < first_cs_cyc, "R10", "reset first",
          first_rst_cyc, first_cs_cyc);
    check(frame == 16'h4456, "R10", "held write frame", int'(frame), 16'h4456);

    // R11: synchronous reset mid-frame
    clear_mon();
    send(2'd3, 12'hABC);
    repeat (60) @(negedge clk);
    check(!dac_cs_n, "R11", "inside frame", dac_cs_n, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!dac_sclk && !dac_sdi && dac_cs_n && dac_load_n && dac_rst_n, "R11",
          "pins idle", {dac_sclk, dac_sdi, dac_cs_n, dac_load_n, dac_rst_n}, 7);
    @(negedge clk);
    check(req_ready, "R11", "ready again", req_ready, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(negedge clk) begin
    if (!finished && cycle > 150000) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog cycles=%0d expected<=%0d", cycle, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule